// File: doc/BRIEF.md
# Switch Forwarding Port-Mask Resolver

This block decides which egress ports one frame of a small Layer-2 switch is sent to. It holds a single table of port masks, one bit per port. For each request it reads three entries of that table and ANDs them together. The first entry is the destination entry. The second is an aggregation entry, picked by the flow's 4-bit link aggregation code, which keeps a single member of a bonded group. The third is a source entry, picked by the ingress port, which says which ports that ingress may reach.

The destination entry comes straight from a MAC-table hit when the address is known. On a miss it comes from one of four flood-index registers, chosen by the frame's traffic class.

A register-style write port loads both the mask table and the flood-index registers. Requests are pipelined. One request is accepted every cycle, and each result appears exactly two cycles later, marked by a valid strobe. With the default parameters the block serves 10 physical ports plus a CPU port, whose bit sits just above the last physical port.

Top module: `fwd_port_resolver`

## Requirements
- R1: After reset, `res_valid` and `err_sticky` are 0. Table entries 0..9 hold only their own port bit (entry i = 1<<i) and every other entry is 0. The flood registers for classes 0, 1, 2 and 3 point at entries 60, 61, 62 and 63.
- R2: A request accepted with `req_valid` high at clock edge k gives `res_valid` high at edge k+2. `res_mask` is then the AND of the destination, aggregation and source entries. `res_valid` is never high without such a request.
- R3: With `req_hit` = 1, the destination entry is table index `req_dst_idx`.
- R4: With `req_hit` = 0, the destination entry is the value of the flood register for `req_class`. The class encoding is 0 = unknown unicast, 1 = broadcast or non-IP multicast, 2 = IPv4 multicast, 3 = IPv6 multicast.
- R5: The aggregation entry is table index 64 + `req_lac`.
- R6: The source entry is table index 80 + `req_port`. Bit j of that entry allows forwarding to port j, and port 10 is the CPU.
- R7: A write with `wr_addr` 0..90 replaces that table entry with `wr_data`. A write with `wr_addr` 0x80..0x83 sets the flood register of class `wr_addr[1:0]` to `wr_data[5:0]`. Writes to any other address change nothing.
- R8: A write takes effect for requests made on the cycle after it. A request made in the same cycle as a write still sees the old value.
- R9: If `req_port` is 11 or more, or if `req_hit` is 1 with `req_dst_idx` of 64 or more, the result mask is 0. In that case `err_sticky` goes to 1 in the same cycle as the result and stays at 1 until reset.
- R10: Back-to-back requests on consecutive cycles each give their own result on consecutive cycles, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 8 | Table index (0..90) or flood register (0x80..0x83) |
| wr_data | input | 11 | Mask value, or flood index in bits 5:0 |
| req_valid | input | 1 | Lookup request strobe |
| req_hit | input | 1 | Destination address known in MAC table |
| req_dst_idx | input | 7 | Destination index from MAC table |
| req_class | input | 2 | Traffic class used on a miss |
| req_lac | input | 4 | Link aggregation code |
| req_port | input | 4 | Ingress port number |
| res_valid | output | 1 | Result strobe, two cycles after the request |
| res_mask | output | 11 | Egress port mask |
| err_sticky | output | 1 | Set by an out-of-range request, cleared by reset |

## Verification
Two things can fall in the same cycle: a configuration write and a lookup that reads the very entry or flood register being written. The bench provokes this by driving both in one cycle, first on a table entry and then on a flood register. It expects the old value for that request and the new value for a request on the next cycle. Its reference model computes every expectation before it applies that cycle's write. Random traffic later mixes writes and lookups freely, so such collisions recur on many table regions under the same ordering rule.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    // Traffic class of a frame whose destination is unknown
    typedef enum logic [1:0] {
        CLS_UCAST = 2'd0,
        CLS_BCAST = 2'd1,
        CLS_IP4MC = 2'd2,
        CLS_IP6MC = 2'd3
    } fwd_class_e;

    localparam int NUM_CLASSES = 4;
    localparam int CLS_W       = 2;

    // Read port assignment of the mask table
    localparam int RD_DST = 0;
    localparam int RD_AGR = 1;
    localparam int RD_SRC = 2;
    localparam int NUM_RD = 3;

endpackage

// File: rtl/fwd_flood_cfg.sv
module fwd_flood_cfg
    import fwd_pkg::*;
#(
    parameter int                FIDX_W      = 6,
    parameter int                ADDR_W      = 8,
    parameter int                DST_ENTRIES = 64,
    parameter logic [ADDR_W-1:0] CFG_BASE    = 8'h80
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [ADDR_W-1:0]                   wr_addr,
    input  logic [FIDX_W-1:0]                   wr_val,
    output logic [NUM_CLASSES-1:0][FIDX_W-1:0]  flood_idx
);

    typedef struct packed {
        logic [NUM_CLASSES-1:0][FIDX_W-1:0] idx;
    } cfg_t;

    cfg_t st_d, st_q;

    // Register block sits on an aligned group of NUM_CLASSES addresses
    logic cfg_sel;
    assign cfg_sel = (wr_addr[ADDR_W-1:CLS_W] == CFG_BASE[ADDR_W-1:CLS_W]);

    function automatic cfg_t cfg_reset();
        cfg_t v;
        for (int c = 0; c < NUM_CLASSES; c++) begin
            v.idx[c] = FIDX_W'(DST_ENTRIES - NUM_CLASSES + c);
        end
        return v;
    endfunction

    always_comb begin
        st_d = st_q;
        if (wr_en && cfg_sel) begin
            st_d.idx[wr_addr[CLS_W-1:0]] = wr_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= cfg_reset();
        end else begin
            st_q <= st_d;
        end
    end

    assign flood_idx = st_q.idx;

endmodule

// File: rtl/fwd_mask_table.sv
module fwd_mask_table
    import fwd_pkg::*;
#(
    parameter int NUM_PHYS  = 10,
    parameter int NUM_PORTS = 11,
    parameter int DEPTH     = 91,
    parameter int TBL_IDX_W = 7,
    parameter int ADDR_W    = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [ADDR_W-1:0]                    wr_addr,
    input  logic [NUM_PORTS-1:0]                 wr_data,
    input  logic [NUM_RD-1:0][TBL_IDX_W-1:0]     rd_idx,
    output logic [NUM_RD-1:0][NUM_PORTS-1:0]     rd_mask
);

    logic [NUM_PORTS-1:0] tbl_d [DEPTH];
    logic [NUM_PORTS-1:0] tbl_q [DEPTH];

    // Unicast entries own exactly their port bit; all others start empty
    function automatic logic [NUM_PORTS-1:0] entry_reset(int i);
        logic [NUM_PORTS-1:0] v;
        v = '0;
        if (i < NUM_PHYS) v[i] = 1'b1;
        return v;
    endfunction

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            tbl_d[i] = tbl_q[i];
            if (wr_en && (wr_addr == ADDR_W'(i))) begin
                tbl_d[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) tbl_q[i] <= entry_reset(i);
        end else begin
            for (int i = 0; i < DEPTH; i++) tbl_q[i] <= tbl_d[i];
        end
    end

    // AND-OR read multiplexers, one per lookup path; an index past DEPTH reads zero
    for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
        always_comb begin
            rd_mask[r] = '0;
            for (int i = 0; i < DEPTH; i++) begin
                if (rd_idx[r] == TBL_IDX_W'(i)) rd_mask[r] = rd_mask[r] | tbl_q[i];
            end
        end
    end

endmodule

// File: rtl/fwd_lookup_pipe.sv
module fwd_lookup_pipe
    import fwd_pkg::*;
#(
    parameter int NUM_PORTS   = 11,
    parameter int DST_ENTRIES = 64,
    parameter int AGGR_BASE   = 64,
    parameter int SRC_BASE    = 80,
    parameter int TBL_IDX_W   = 7,
    parameter int FIDX_W      = 6,
    parameter int DIDX_W      = 7,
    parameter int LAC_W       = 4,
    parameter int PORT_W      = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                req_valid,
    input  logic                                req_hit,
    input  logic [DIDX_W-1:0]                   req_dst_idx,
    input  fwd_class_e                          req_class,
    input  logic [LAC_W-1:0]                    req_lac,
    input  logic [PORT_W-1:0]                   req_port,
    input  logic [NUM_CLASSES-1:0][FIDX_W-1:0]  flood_idx,
    output logic [NUM_RD-1:0][TBL_IDX_W-1:0]    rd_idx,
    input  logic [NUM_RD-1:0][NUM_PORTS-1:0]    rd_mask,
    output logic                                res_valid,
    output logic [NUM_PORTS-1:0]                res_mask,
    output logic                                err_sticky
);

    typedef struct packed {
        logic                 s1_valid;
        logic                 s1_bad;
        logic [NUM_PORTS-1:0] s1_dst;
        logic [NUM_PORTS-1:0] s1_agr;
        logic [NUM_PORTS-1:0] s1_src;
        logic                 s2_valid;
        logic [NUM_PORTS-1:0] s2_mask;
        logic                 err;
    } pipe_t;

    pipe_t st_d, st_q;

    logic              dst_oob;
    logic              port_oob;
    logic [FIDX_W-1:0] dst_sel;

    assign dst_oob  = req_hit && (req_dst_idx >= DIDX_W'(DST_ENTRIES));
    assign port_oob = (req_port >= PORT_W'(NUM_PORTS));
    assign dst_sel  = req_hit ? req_dst_idx[FIDX_W-1:0] : flood_idx[req_class];

    always_comb begin
        rd_idx[RD_DST] = TBL_IDX_W'(dst_sel);
        rd_idx[RD_AGR] = TBL_IDX_W'(AGGR_BASE) + TBL_IDX_W'(req_lac);
        rd_idx[RD_SRC] = TBL_IDX_W'(SRC_BASE)  + TBL_IDX_W'(req_port);
    end

    always_comb begin
        st_d = st_q;
        // Stage 1: capture the three table reads of the request
        st_d.s1_valid = req_valid;
        st_d.s1_bad   = req_valid && (dst_oob || port_oob);
        if (req_valid) begin
            st_d.s1_dst = rd_mask[RD_DST];
            st_d.s1_agr = rd_mask[RD_AGR];
            st_d.s1_src = rd_mask[RD_SRC];
        end
        // Stage 2: combine and flag
        st_d.s2_valid = st_q.s1_valid;
        if (st_q.s1_valid) begin
            st_d.s2_mask = st_q.s1_bad ? '0 : (st_q.s1_dst & st_q.s1_agr & st_q.s1_src);
        end
        st_d.err = st_q.err | (st_q.s1_valid & st_q.s1_bad);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid  = st_q.s2_valid;
    assign res_mask   = st_q.s2_mask;
    assign err_sticky = st_q.err;

endmodule

// File: rtl/fwd_port_resolver.sv
module fwd_port_resolver
    import fwd_pkg::*;
#(
    parameter int                NUM_PHYS     = 10,
    parameter int                DST_ENTRIES  = 64,
    parameter int                AGGR_ENTRIES = 16,
    parameter int                ADDR_W       = 8,
    parameter logic [ADDR_W-1:0] CFG_BASE     = 8'h80,
    parameter int                NUM_PORTS    = NUM_PHYS + 1,
    parameter int                FIDX_W       = $clog2(DST_ENTRIES),
    parameter int                DIDX_W       = FIDX_W + 1,
    parameter int                LAC_W        = $clog2(AGGR_ENTRIES),
    parameter int                PORT_W       = $clog2(NUM_PORTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [NUM_PORTS-1:0] wr_data,
    input  logic                 req_valid,
    input  logic                 req_hit,
    input  logic [DIDX_W-1:0]    req_dst_idx,
    input  logic [1:0]           req_class,
    input  logic [LAC_W-1:0]     req_lac,
    input  logic [PORT_W-1:0]    req_port,
    output logic                 res_valid,
    output logic [NUM_PORTS-1:0] res_mask,
    output logic                 err_sticky
);

    localparam int AGGR_BASE = DST_ENTRIES;
    localparam int SRC_BASE  = AGGR_BASE + AGGR_ENTRIES;
    localparam int DEPTH     = SRC_BASE + NUM_PORTS;
    localparam int TBL_IDX_W = $clog2(DEPTH);

    logic [NUM_CLASSES-1:0][FIDX_W-1:0] flood_idx;
    logic [NUM_RD-1:0][TBL_IDX_W-1:0]   rd_idx;
    logic [NUM_RD-1:0][NUM_PORTS-1:0]   rd_mask;

    fwd_flood_cfg #(
        .FIDX_W      (FIDX_W),
        .ADDR_W      (ADDR_W),
        .DST_ENTRIES (DST_ENTRIES),
        .CFG_BASE    (CFG_BASE)
    ) u_flood (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_val    (wr_data[FIDX_W-1:0]),
        .flood_idx (flood_idx)
    );

    fwd_mask_table #(
        .NUM_PHYS  (NUM_PHYS),
        .NUM_PORTS (NUM_PORTS),
        .DEPTH     (DEPTH),
        .TBL_IDX_W (TBL_IDX_W),
        .ADDR_W    (ADDR_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_mask (rd_mask)
    );

    fwd_lookup_pipe #(
        .NUM_PORTS   (NUM_PORTS),
        .DST_ENTRIES (DST_ENTRIES),
        .AGGR_BASE   (AGGR_BASE),
        .SRC_BASE    (SRC_BASE),
        .TBL_IDX_W   (TBL_IDX_W),
        .FIDX_W      (FIDX_W),
        .DIDX_W      (DIDX_W),
        .LAC_W       (LAC_W),
        .PORT_W      (PORT_W)
    ) u_pipe (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_hit     (req_hit),
        .req_dst_idx (req_dst_idx),
        .req_class   (fwd_class_e'(req_class)),
        .req_lac     (req_lac),
        .req_port    (req_port),
        .flood_idx   (flood_idx),
        .rd_idx      (rd_idx),
        .rd_mask     (rd_mask),
        .res_valid   (res_valid),
        .res_mask    (res_mask),
        .err_sticky  (err_sticky)
    );

endmodule

// File: rtl/fwd_port_resolver_chk.sv
module fwd_port_resolver_chk #(
    parameter int NUM_PORTS   = 11,
    parameter int DST_ENTRIES = 64,
    parameter int DIDX_W      = 7,
    parameter int PORT_W      = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_hit,
    input logic [DIDX_W-1:0]    req_dst_idx,
    input logic [PORT_W-1:0]    req_port,
    input logic                 res_valid,
    input logic [NUM_PORTS-1:0] res_mask,
    input logic                 err_sticky
);

    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (!rst_n) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R2
    req_to_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ##2 res_valid);

    // R2
    no_spurious_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && res_valid) |-> $past(req_valid, 2));

    // R9
    bad_port_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_port >= PORT_W'(NUM_PORTS)) |-> ##2 (res_valid && res_mask == '0 && err_sticky));

    // R9
    bad_dst_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_hit && req_dst_idx >= DIDX_W'(DST_ENTRIES)) |-> ##2 (res_mask == '0 && err_sticky));

    // R9
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);

    // R9
    err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_sticky) |-> (res_valid && res_mask == '0));

endmodule

bind fwd_port_resolver fwd_port_resolver_chk #(
    .NUM_PORTS   (NUM_PORTS),
    .DST_ENTRIES (DST_ENTRIES),
    .DIDX_W      (DIDX_W),
    .PORT_W      (PORT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_hit     (req_hit),
    .req_dst_idx (req_dst_idx),
    .req_port    (req_port),
    .res_valid   (res_valid),
    .res_mask    (res_mask),
    .err_sticky  (err_sticky)
);

// File: tb/fwd_port_resolver_tb.sv
`timescale 1ns/1ps
module fwd_port_resolver_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [10:0] wr_data = '0;
    logic        req_valid = 1'b0;
    logic        req_hit = 1'b0;
    logic [6:0]  req_dst_idx = '0;
    logic [1:0]  req_class = '0;
    logic [3:0]  req_lac = '0;
    logic [3:0]  req_port = '0;
    logic        res_valid;
    logic [10:0] res_mask;
    logic        err_sticky;

    always #2.5 clk = ~clk;

    fwd_port_resolver u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .req_valid(req_valid), .req_hit(req_hit), .req_dst_idx(req_dst_idx),
        .req_class(req_class), .req_lac(req_lac), .req_port(req_port),
        .res_valid(res_valid), .res_mask(res_mask), .err_sticky(err_sticky)
    );

    typedef struct {
        logic [10:0] mask;
        logic        bad;
        int          cyc;
        int          tag;
    } item_t;

    item_t       sb_q[$];
    logic [10:0] m_tbl [91];
    logic [5:0]  m_flood [4];
    logic        exp_err = 1'b0;
    int          cycle_cnt = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    always @(posedge clk) cycle_cnt <= cycle_cnt + 1;

    task automatic check(input bit ok, input int tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Reference model built from the requirements (R1 reset image)
    task automatic model_reset();
        for (int i = 0; i < 91; i++) m_tbl[i] = (i < 10) ? (11'd1 << i) : 11'd0;
        for (int c = 0; c < 4; c++) m_flood[c] = 6'(60 + c);
        exp_err = 1'b0;
    endtask

    // Driver: one cycle of stimulus; expectation uses the state before this cycle's write (R8)
    task automatic drive(input logic we, input logic [7:0] wa, input logic [10:0] wd,
                         input logic rv, input logic hit, input logic [6:0] di,
                         input logic [1:0] cl, input logic [3:0] lac, input logic [3:0] pt,
                         input int tag);
        item_t it;
        int    d;
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd;
        req_valid = rv; req_hit = hit; req_dst_idx = di;
        req_class = cl; req_lac = lac; req_port = pt;
        if (rv) begin
            it.bad = (pt >= 4'd11) || (hit && di >= 7'd64);
            d      = hit ? int'(di) : int'(m_flood[cl]);
            it.mask = it.bad ? 11'd0 : (m_tbl[d] & m_tbl[64 + int'(lac)] & m_tbl[80 + int'(pt)]);
            it.cyc = cycle_cnt;
            it.tag = tag;
            sb_q.push_back(it);
        end
        if (we) begin
            if (wa < 8'd91) m_tbl[wa] = wd;
            else if (wa >= 8'h80 && wa <= 8'h83) m_flood[wa[1:0]] = wd[5:0];
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [10:0] d, input int tag);
        drive(1'b1, a, d, 1'b0, 1'b0, 7'd0, 2'd0, 4'd0, 4'd0, tag);
    endtask

    task automatic lk(input logic hit, input logic [6:0] di, input logic [1:0] cl,
                      input logic [3:0] lac, input logic [3:0] pt, input int tag);
        drive(1'b0, 8'd0, 11'd0, 1'b1, hit, di, cl, lac, pt, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 8'd0, 11'd0, 1'b0, 1'b0, 7'd0, 2'd0, 4'd0, 4'd0, 0);
    endtask

    // Monitor: pops the scoreboard as results appear (R2, R10, R9)
    always @(negedge clk) begin
        if (rst_n && !finished && res_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, 2, "result without request", 32'(res_mask), 32'h0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                check(res_mask === it.mask, it.tag, "mask", 32'(res_mask), 32'(it.mask));
                check(cycle_cnt == it.cyc + 2, 2, "latency", 32'(cycle_cnt - it.cyc), 32'd2);
                exp_err = exp_err | it.bad;
                check(err_sticky === exp_err, 9, "err_sticky", 32'(err_sticky), 32'(exp_err));
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL R2 watchdog expired: actual 0x0 expected 0x1");
            summary();
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset outputs
        check(res_valid === 1'b0, 1, "res_valid after reset", 32'(res_valid), 32'h0);
        check(err_sticky === 1'b0, 1, "err_sticky after reset", 32'(err_sticky), 32'h0);
        // R1: aggregation/source entries empty, so result is zero
        lk(1'b1, 7'd3, 2'd0, 4'd0, 4'd3, 1);
        idle(3);

        // R7: open aggregation and source regions
        for (int i = 64; i < 91; i++) wr(8'(i), 11'h7FF, 7);
        // R3 R10 R1: back-to-back hits on the unicast entries, then non-unicast entries
        for (int i = 0; i < 10; i++) lk(1'b1, 7'(i), 2'd0, 4'd0, 4'(i), 3);
        lk(1'b1, 7'd10, 2'd0, 4'd0, 4'd0, 1);
        lk(1'b1, 7'd59, 2'd0, 4'd0, 4'd0, 1);
        // R4 R1: default flood entries are empty
        for (int c = 0; c < 4; c++) lk(1'b0, 7'd0, 2'(c), 4'd0, 4'd1, 4);
        // R4 R1: distinct patterns on 60..63 reveal the class-to-entry map
        wr(8'd60, 11'h001, 4); wr(8'd61, 11'h012, 4); wr(8'd62, 11'h124, 4); wr(8'd63, 11'h648, 4);
        for (int c = 0; c < 4; c++) lk(1'b0, 7'd5, 2'(c), 4'd2, 4'd2, 4);
        // R7 R4: repoint unicast flood
        wr(8'd20, 11'h2AA, 7); wr(8'h80, 11'd20, 7);
        lk(1'b0, 7'd0, 2'd0, 4'd0, 4'd0, 4);
        // R5: aggregation code selects its entry
        wr(8'd30, 11'h7FF, 7); wr(8'd69, 11'h0F0, 5);
        lk(1'b1, 7'd30, 2'd0, 4'd5, 4'd0, 5);
        lk(1'b1, 7'd30, 2'd0, 4'd6, 4'd0, 5);
        // R6: source entry per ingress port, CPU port 10
        wr(8'd83, 11'h00F, 6); wr(8'd90, 11'h400, 6);
        lk(1'b1, 7'd30, 2'd0, 4'd1, 4'd3, 6);
        lk(1'b1, 7'd30, 2'd0, 4'd1, 4'd10, 6);
        // R8: same-cycle write sees old value, next cycle sees new
        drive(1'b1, 8'd30, 11'h155, 1'b1, 1'b1, 7'd30, 2'd0, 4'd1, 4'd0, 8);
        lk(1'b1, 7'd30, 2'd0, 4'd1, 4'd0, 8);
        // R8: same for a flood register
        drive(1'b1, 8'h81, 11'd30, 1'b1, 1'b0, 7'd0, 2'd1, 4'd1, 4'd0, 8);
        lk(1'b0, 7'd0, 2'd1, 4'd1, 4'd0, 8);
        // R7: writes outside both regions change nothing
        wr(8'd100, 11'h000, 7); wr(8'h84, 11'd0, 7); wr(8'hFF, 11'd0, 7);
        for (int c = 0; c < 4; c++) lk(1'b0, 7'd0, 2'(c), 4'd1, 4'd0, 7);
        lk(1'b1, 7'd30, 2'd0, 4'd1, 4'd0, 7);
        idle(3);
        check(err_sticky === 1'b0, 9, "err before any bad request", 32'(err_sticky), 32'h0);
        // R9: out-of-range ingress port, then good lookup, then bad destination
        lk(1'b1, 7'd30, 2'd0, 4'd1, 4'd11, 9);
        lk(1'b1, 7'd30, 2'd0, 4'd1, 4'd0, 9);
        lk(1'b1, 7'd64, 2'd0, 4'd1, 4'd0, 9);
        lk(1'b1, 7'd127, 2'd0, 4'd1, 4'd15, 9);
        idle(3);
        // R2 R10: random mix of writes and lookups
        for (int n = 0; n < 400; n++) begin
            logic [7:0] wa;
            int sel;
            sel = int'($urandom_range(0, 9));
            wa  = (sel < 6) ? 8'($urandom_range(0, 90)) :
                  (sel < 9) ? 8'($urandom_range(128, 131)) : 8'($urandom_range(91, 255));
            drive(($urandom_range(0, 3) == 0), wa, 11'($urandom()),
                  ($urandom_range(0, 3) != 0), 1'($urandom()),
                  ($urandom_range(0, 15) == 0) ? 7'($urandom_range(64, 127)) : 7'($urandom_range(0, 63)),
                  2'($urandom()), 4'($urandom()),
                  ($urandom_range(0, 15) == 0) ? 4'($urandom_range(11, 15)) : 4'($urandom_range(0, 10)),
                  10);
        end
        idle(4);
        check(sb_q.size() == 0, 2, "outstanding results", 32'(sb_q.size()), 32'h0);
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule